// File: doc/BRIEF.md
# Packed and Linked Adder Array

A combinational adder datapath built from a chain of narrow adder slices (two 8-bit slices by default). A two-bit mode input selects how the slices are used. In linked mode the slices form one wide adder, with the carry out of each slice feeding the carry in of the slice above it. In packed mode each slice carries its own independent narrow addition. The top bit of each slice is forced to zero and acts as a guard, so a carry from one field stops there and cannot reach the next field. In extended mode one addition narrower than the full width runs on the whole chain: its operands are zero-extended and the surplus result bits are dropped.

Packing N additions of width w into one adder needs at least N*w + (N-1) bits. Each slice here has one guard bit, so the slice width is the field width plus one. Outputs that do not belong to the active mode are held at zero.

Top module: `adder_fabric`

## Requirements
- R1: The mode encoding is 2'b00 extended, 2'b01 packed and 2'b10 linked.
- R2: In packed mode, field g is read from operand bits [8g+6:8g]. Its 7-bit sum goes to pk_sum[7g+6:7g], and its carry goes to pk_cy[g], which is taken from the guard position 8g+7.
- R3: In packed mode, a carry out of one field never changes another field's sum or carry.
- R4: In packed mode, the operand bits in the guard positions (bits 7 and 15) have no effect on any output.
- R5: In linked mode, wide_sum is the 16-bit sum of op_a and op_b, and the carry out of the lower slice propagates into the upper slice.
- R6: In linked mode, wide_cy is the carry out of the full 16-bit addition.
- R7: In extended mode, wide_sum[11:0] is the sum of op_a[11:0] and op_b[11:0], and wide_cy is its carry out. wide_sum[15:12] is zero, and op_a[15:12] and op_b[15:12] have no effect.
- R8: With mode 2'b11, every output is zero.
- R9: pk_sum and pk_cy are zero outside packed mode, and wide_sum and wide_cy are zero in packed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | Operating mode select |
| op_a | input | 16 | First operand bus |
| op_b | input | 16 | Second operand bus |
| pk_sum | output | 14 | Packed-mode field sums, 7 bits per field |
| pk_cy | output | 2 | Packed-mode carry out per field |
| wide_sum | output | 16 | Linked- or extended-mode sum |
| wide_cy | output | 1 | Linked- or extended-mode carry out |

## Verification
The block has no internal state, so a fault appears at the ports in the same cycle the operands are applied. A broken guard mask or a broken carry link shows up at once as a wrong field sum or a missing carry. The stimulus therefore aims at carry boundaries: a field that overflows into its guard position, and a lower slice that overflows into the upper slice. Set guard bits and set upper operand bits in extended mode expose any leakage through positions that must be ignored.

// File: rtl/adder_fabric.sv
module adder_fabric #(
  parameter int SLICE_W  = 8,
  parameter int SLICES   = 2,
  parameter int NARROW_W = 12,
  localparam int WIDE_W  = SLICE_W * SLICES,
  localparam int FLD_W   = SLICE_W - 1
) (
  input  logic [1:0]              mode,
  input  logic [WIDE_W-1:0]       op_a,
  input  logic [WIDE_W-1:0]       op_b,
  output logic [SLICES*FLD_W-1:0] pk_sum,
  output logic [SLICES-1:0]       pk_cy,
  output logic [WIDE_W-1:0]       wide_sum,
  output logic                    wide_cy
);

  localparam logic [1:0] M_EXT  = 2'b00;
  localparam logic [1:0] M_PACK = 2'b01;
  localparam logic [1:0] M_LINK = 2'b10;

  logic [WIDE_W-1:0] in_mask, xa, xb, raw;
  logic [SLICES:0]   cy;
  logic              is_pack;

  always_comb begin
    case (mode)
      M_EXT:   in_mask = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
      M_PACK:  in_mask = {SLICES{{1'b0, {FLD_W{1'b1}}}}};
      M_LINK:  in_mask = '1;
      default: in_mask = '0;
    endcase
  end

  assign xa      = op_a & in_mask;
  assign xb      = op_b & in_mask;
  assign cy[0]   = 1'b0;
  assign is_pack = (mode == M_PACK);

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    assign {cy[g+1], raw[g*SLICE_W +: SLICE_W]} =
        {1'b0, xa[g*SLICE_W +: SLICE_W]} + {1'b0, xb[g*SLICE_W +: SLICE_W]}
        + {{SLICE_W{1'b0}}, cy[g]};
    assign pk_sum[g*FLD_W +: FLD_W] = is_pack ? raw[g*SLICE_W +: FLD_W] : '0;
    assign pk_cy[g] = is_pack & raw[g*SLICE_W + FLD_W];
  end

  always_comb begin
    case (mode)
      M_EXT: begin
        wide_sum = {{(WIDE_W-NARROW_W){1'b0}}, raw[NARROW_W-1:0]};
        wide_cy  = raw[NARROW_W];
      end
      M_LINK: begin
        wide_sum = raw;
        wide_cy  = cy[SLICES];
      end
      default: begin
        wide_sum = '0;
        wide_cy  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/adder_fabric_chk.sv
module adder_fabric_chk #(
  parameter int SLICE_W  = 8,
  parameter int SLICES   = 2,
  parameter int NARROW_W = 12,
  localparam int WIDE_W  = SLICE_W * SLICES,
  localparam int FLD_W   = SLICE_W - 1
) (
  input logic [1:0]              mode,
  input logic [WIDE_W-1:0]       op_a,
  input logic [WIDE_W-1:0]       op_b,
  input logic [SLICES*FLD_W-1:0] pk_sum,
  input logic [SLICES-1:0]       pk_cy,
  input logic [WIDE_W-1:0]       wide_sum,
  input logic                    wide_cy
);

  always_comb begin
    if (mode == 2'b01) begin
      for (int g = 0; g < SLICES; g++) begin
        a_r2_field_sum: assert ({pk_cy[g], pk_sum[g*FLD_W +: FLD_W]} ==
          ({1'b0, op_a[g*SLICE_W +: FLD_W]} + {1'b0, op_b[g*SLICE_W +: FLD_W]}))
          else $error("packed field %0d wrong", g);
      end
      a_r9_wide_idle: assert (wide_sum == '0 && !wide_cy)
        else $error("wide outputs active in packed mode");
    end else begin
      a_r9_pack_idle: assert (pk_sum == '0 && pk_cy == '0)
        else $error("packed outputs active outside packed mode");
    end
    if (mode == 2'b10) begin
      a_r5_linked_sum: assert ({wide_cy, wide_sum} == ({1'b0, op_a} + {1'b0, op_b}))
        else $error("linked sum wrong");
    end
    if (mode == 2'b00) begin
      a_r7_ext_sum: assert ({wide_cy, wide_sum[NARROW_W-1:0]} ==
        ({1'b0, op_a[NARROW_W-1:0]} + {1'b0, op_b[NARROW_W-1:0]}))
        else $error("extended sum wrong");
      a_r7_ext_upper: assert (wide_sum[WIDE_W-1:NARROW_W] == '0)
        else $error("extended upper bits nonzero");
    end
    if (mode == 2'b11) begin
      a_r8_reserved_zero: assert (wide_sum == '0 && !wide_cy && pk_sum == '0 && pk_cy == '0)
        else $error("reserved mode outputs nonzero");
    end
  end

endmodule

bind adder_fabric adder_fabric_chk #(
  .SLICE_W(SLICE_W), .SLICES(SLICES), .NARROW_W(NARROW_W)
) u_chk (
  .mode(mode), .op_a(op_a), .op_b(op_b), .pk_sum(pk_sum),
  .pk_cy(pk_cy), .wide_sum(wide_sum), .wide_cy(wide_cy)
);

// File: tb/test_adder_fabric.sv
`timescale 1ns/1ps
module test_adder_fabric;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  mode = 2'b11;
  logic [15:0] op_a = 16'hFFFF, op_b = 16'hFFFF;
  logic [13:0] pk_sum;
  logic [1:0]  pk_cy;
  logic [15:0] wide_sum;
  logic        wide_cy;

  adder_fabric i_adder_fabric (
    .mode(mode), .op_a(op_a), .op_b(op_b), .pk_sum(pk_sum),
    .pk_cy(pk_cy), .wide_sum(wide_sum), .wide_cy(wide_cy)
  );

  typedef struct {
    string       tag;
    logic [13:0] ps;
    logic [1:0]  pc;
    logic [15:0] ws;
    logic        wc;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic drive(input string tag, input logic [1:0] m,
                       input logic [15:0] a, input logic [15:0] b);
    item_t it;
    logic [7:0]  f0, f1;
    logic [12:0] e;
    logic [16:0] l;
    it.tag = tag; it.ps = '0; it.pc = '0; it.ws = '0; it.wc = 1'b0;
    case (m)
      2'b00: begin
        e = {1'b0, a[11:0]} + {1'b0, b[11:0]};
        it.ws = {4'h0, e[11:0]}; it.wc = e[12];
      end
      2'b01: begin
        f0 = {1'b0, a[6:0]} + {1'b0, b[6:0]};
        f1 = {1'b0, a[14:8]} + {1'b0, b[14:8]};
        it.ps = {f1[6:0], f0[6:0]}; it.pc = {f1[7], f0[7]};
      end
      2'b10: begin
        l = {1'b0, a} + {1'b0, b};
        it.ws = l[15:0]; it.wc = l[16];
      end
      default: ;
    endcase
    @(posedge clk);
    mode <= m; op_a <= a; op_b <= b;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (pk_sum !== it.ps || pk_cy !== it.pc || wide_sum !== it.ws || wide_cy !== it.wc) begin
        n_fail++;
        $display("FAIL %s: got ps=%h pc=%b ws=%h wc=%b exp ps=%h pc=%b ws=%h wc=%b",
                 it.tag, pk_sum, pk_cy, wide_sum, wide_cy, it.ps, it.pc, it.ws, it.wc);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    drive("R8 reset state reserved mode", 2'b11, 16'hFFFF, 16'hFFFF);
    drive("R5 R1 linked basic",           2'b10, 16'h1234, 16'h4321);
    drive("R5 linked slice carry",        2'b10, 16'h00FF, 16'h0001);
    drive("R6 linked carry out",          2'b10, 16'hFFFF, 16'h0001);
    drive("R6 linked max",                2'b10, 16'hFFFF, 16'hFFFF);
    drive("R2 R9 packed basic",           2'b01, 16'h0305, 16'h0102);
    drive("R3 packed carry isolation",    2'b01, 16'h007F, 16'h0001);
    drive("R3 packed both overflow",      2'b01, 16'h7F7F, 16'h7F7F);
    drive("R4 packed guard bits ignored", 2'b01, 16'h8080, 16'h8080);
    drive("R4 packed guards with data",   2'b01, 16'hC1FF, 16'h8181);
    drive("R7 extended carry, upper ignored", 2'b00, 16'hF800, 16'hF800);
    drive("R7 R9 extended basic",         2'b00, 16'hABCD, 16'h1234);
    drive("R8 reserved after activity",   2'b11, 16'h1234, 16'h4321);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule